// File: doc/BRIEF.md
# Real-Time Clock Bus Command Front-End

This block is the I2C target side of a real-time clock. It answers a run of eight consecutive 7-bit addresses. The upper four address bits are fixed by a parameter. The low three bits name the command, so no register-pointer byte is needed. A read moves the selected register group out byte by byte. A write hands each received byte to the clock counter or to the alarm comparator, both of which sit outside this block. Every byte travels with its bit order reversed: the first bit on the wire is bit 0 of the internal register.

The block owns both status registers. The first holds the power-on, low-battery, interrupt-pending and 24-hour flags, and it takes a write-only command that reinitialises the clock. Some of these flags clear when the register is read. The second holds the interrupt mode and a test bit. After reset the block stays off the bus for a set number of cycles while the power-on detector settles. SCL and SDA are sampled with the system clock, and SDA is driven low through an open-drain enable.

Top module: `rtc_i2c_front`

## Requirements
- R1: An address phase is acknowledged when address bits 6:3 equal `ADDR_HI`. All eight values of bits 2:0 are acknowledged. Any other address gets no acknowledge.
- R2: Bytes go MSB-first on the wire. The wire byte is the bit-reverse of the internal value, in both directions, so internal bit 0 is the first bit on the bus.
- R3: A read returns its group from internal byte 0 upward, one byte per acknowledged byte. The groups are:
  - command 0: status 1 (one byte)
  - command 1: status 2 (one byte)
  - command 2: seven time bytes, byte i taken from `time_in[8i+7:8i]`, in the order year, month, day, weekday, hour, minute, second
  - command 3: hour, minute and second only (time bytes 4 to 6)
  - command 5: three alarm bytes from `alarm_in[8i+7:8i]`

  Bytes past the end of a group, and every byte of commands 4, 6 and 7, read as 0xFF.
- R4: Received bytes go out as one-cycle strobes carrying `wr_idx` and `wr_data`, the latter already un-reversed:
  - command 2: byte i gives `wr_time` with index i
  - command 3: byte i gives `wr_time` with index i+4
  - command 5: byte i gives `wr_alarm` with index i

  Bytes past the end of a group, and writes to commands 4, 6 and 7, produce no strobe. The two strobes are never high together.
- R5: Status 1 reads as follows:
  - bit 0: power-on flag, which is 1 after reset
  - bit 1: low battery, set while `batt_low` is high
  - bit 2: interrupt pending
  - bit 6: 24-hour mode
  - bit 7 and bits 5:3: always 0

  After reset, `sda_oe`, `irq` and `hour24` are 0.
- R6: A read of status 1 returns the flags as they were, then clears power-on, low-battery and pending. A set condition present in the same cycle wins over the clear.
- R7: Any write to status 1 loads bit 6 into the 24-hour flag. When bit 7 is also 1, the write clears the power-on, low-battery and pending flags, clears status 2, and pulses `clk_rst` for one cycle. The 24-hour flag still holds the bit 6 just written.
- R8: Status 2 stores the written byte and reads it back. Bits 7:4 drive `int_mode`, where 0x0 is none, 0x1 frequency, 0x2 per-minute edge and 0x4 alarm. Bit 0 drives `test_mode`.
- R9: An `alarm_hit` pulse sets pending only while the interrupt mode is not none. `irq` is high while pending is set and the mode is not none. Writing status 2 with mode none clears pending and drops `irq`.
- R10: For `POR_CYCLES` cycles after reset no address is acknowledged and SDA is never driven.
- R11: A master NACK after a read byte ends the transfer and releases SDA. A repeated start begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| time_in | input | 56 | Current time, seven bytes, byte 0 in the low bits |
| alarm_in | input | 24 | Alarm setting, three bytes, byte 0 in the low bits |
| wr_time | output | 1 | One-cycle strobe: write a time byte |
| wr_alarm | output | 1 | One-cycle strobe: write an alarm byte |
| wr_idx | output | 3 | Byte index for the strobe |
| wr_data | output | 8 | Un-reversed byte for the strobe |
| batt_low | input | 1 | Low-battery condition from the supply monitor |
| alarm_hit | input | 1 | Interrupt event pulse from the alarm or frequency logic |
| irq | output | 1 | Interrupt request |
| int_mode | output | 4 | Interrupt mode from status 2 |
| test_mode | output | 1 | Test bit from status 2 |
| hour24 | output | 1 | 24-hour mode flag |
| clk_rst | output | 1 | One-cycle reinitialise pulse to the clock counter |

## Verification
A flag can be set and read-cleared in the same cycle. The low-battery set and the status-1 read-clear meet when `batt_low` is held high across a status-1 read. The bench then expects the next read to report the flag again. A second read taken after the condition is dropped must report it one more time, and a third must report it clear. The alarm event and the write of interrupt mode none are exercised back to back. After such a write, `irq` must stay low and no later event may set pending.

// File: rtl/rtc_i2c_front.sv
module rtc_i2c_front #(
  parameter logic [3:0]  ADDR_HI    = 4'b0110,
  parameter int unsigned POR_CYCLES = 16_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [55:0] time_in,
  input  logic [23:0] alarm_in,
  output logic        wr_time,
  output logic        wr_alarm,
  output logic [2:0]  wr_idx,
  output logic [7:0]  wr_data,
  input  logic        batt_low,
  input  logic        alarm_hit,
  output logic        irq,
  output logic [3:0]  int_mode,
  output logic        test_mode,
  output logic        hour24,
  output logic        clk_rst
);
  localparam int PW = (POR_CYCLES < 2) ? 1 : $clog2(POR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  logic [2:0] scl_s, sda_s;
  logic       rise, fall, start, stop, sda_b;
  st_t        state;
  logic [3:0] cnt;
  logic [7:0] sr, tx;
  logic [2:0] cmd, idx, idx_nx, tix;
  logic       rnw, nack;
  logic       ev_rd1, ev_wr1, ev_wr2;
  logic       st_poc, st_bld, st_pend, st_24h;
  logic [7:0] st2, st1, rb, rb_rev;
  logic [PW-1:0] por_cnt;
  logic       busy;
  logic [63:0] tpad, apad;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 3'b111;
      sda_s <= 3'b111;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end

  assign sda_b = sda_s[1];
  assign rise  = scl_s[1] & ~scl_s[2];
  assign fall  = ~scl_s[1] & scl_s[2];
  assign start = scl_s[1] & scl_s[2] & sda_s[2] & ~sda_s[1];
  assign stop  = scl_s[1] & scl_s[2] & ~sda_s[2] & sda_s[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) por_cnt <= PW'(POR_CYCLES);
    else if (por_cnt != '0) por_cnt <= por_cnt - PW'(1);
  assign busy = (por_cnt != '0);

  assign st1    = {1'b0, st_24h, 3'b000, st_pend, st_bld, st_poc};
  assign tpad   = {8'hFF, time_in};
  assign apad   = {40'hFF_FFFF_FFFF, alarm_in};
  assign tix    = (cmd == 3'd3) ? idx + 3'd4 : idx;
  assign idx_nx = (idx == 3'd7) ? idx : idx + 3'd1;

  always_comb begin
    rb = 8'hFF;
    case (cmd)
      3'd0: if (idx == 3'd0) rb = st1;
      3'd1: if (idx == 3'd0) rb = st2;
      3'd2: if (idx < 3'd7) rb = tpad[{tix, 3'b000} +: 8];
      3'd3: if (idx < 3'd3) rb = tpad[{tix, 3'b000} +: 8];
      3'd5: if (idx < 3'd3) rb = apad[{idx, 3'b000} +: 8];
      default: rb = 8'hFF;
    endcase
  end
  assign rb_rev = rev8(rb);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; sr <= '0; tx <= 8'hFF;
      cmd <= '0; idx <= '0; rnw <= 1'b0; nack <= 1'b1; sda_oe <= 1'b0;
      ev_rd1 <= 1'b0; ev_wr1 <= 1'b0; ev_wr2 <= 1'b0;
      wr_time <= 1'b0; wr_alarm <= 1'b0; wr_idx <= '0; wr_data <= '0;
    end else begin
      ev_rd1 <= 1'b0; ev_wr1 <= 1'b0; ev_wr2 <= 1'b0;
      wr_time <= 1'b0; wr_alarm <= 1'b0;
      if (start) begin
        state <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop) begin
        state <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR:
            if (rise) begin
              sr <= {sr[6:0], sda_b}; cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8) begin
              if (sr[7:4] == ADDR_HI && !busy) begin
                sda_oe <= 1'b1; cmd <= sr[3:1]; rnw <= sr[0]; idx <= '0;
                state <= S_AACK;
              end else state <= S_IDLE;
            end
          S_AACK:
            if (fall) begin
              cnt <= '0;
              if (rnw) begin
                tx <= rb_rev; sda_oe <= ~rb_rev[7];
                ev_rd1 <= (cmd == 3'd0) && (idx == 3'd0);
                idx <= idx_nx; state <= S_RD;
              end else begin
                sda_oe <= 1'b0; state <= S_WR;
              end
            end
          S_WR:
            if (rise) begin
              sr <= {sr[6:0], sda_b}; cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8) begin
              sda_oe  <= 1'b1;
              wr_data <= rev8(sr);
              ev_wr1  <= (cmd == 3'd0) && (idx == 3'd0);
              ev_wr2  <= (cmd == 3'd1) && (idx == 3'd0);
              wr_time <= ((cmd == 3'd2) && (idx < 3'd7)) || ((cmd == 3'd3) && (idx < 3'd3));
              wr_alarm <= (cmd == 3'd5) && (idx < 3'd3);
              wr_idx  <= tix;
              idx <= idx_nx; state <= S_WACK;
            end
          S_WACK:
            if (fall) begin
              sda_oe <= 1'b0; cnt <= '0; state <= S_WR;
            end
          S_RD:
            if (fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0; state <= S_RACK;
              end else begin
                tx <= {tx[6:0], 1'b1}; sda_oe <= ~tx[6]; cnt <= cnt + 4'd1;
              end
            end
          S_RACK:
            if (rise) nack <= sda_b;
            else if (fall) begin
              if (nack) state <= S_IDLE;
              else begin
                tx <= rb_rev; sda_oe <= ~rb_rev[7];
                ev_rd1 <= (cmd == 3'd0) && (idx == 3'd0);
                idx <= idx_nx; cnt <= '0; state <= S_RD;
              end
            end
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_poc <= 1'b1; st_bld <= 1'b0; st_pend <= 1'b0; st_24h <= 1'b0;
      st2 <= '0; clk_rst <= 1'b0;
    end else begin
      clk_rst <= 1'b0;
      if (ev_rd1) begin
        st_poc <= 1'b0; st_bld <= 1'b0; st_pend <= 1'b0;
      end
      if (ev_wr1) begin
        st_24h <= wr_data[6];
        if (wr_data[7]) begin
          st_poc <= 1'b0; st_bld <= 1'b0; st_pend <= 1'b0;
          st2 <= '0; clk_rst <= 1'b1;
        end
      end
      if (ev_wr2) begin
        st2 <= wr_data;
        if (wr_data[7:4] == 4'h0) st_pend <= 1'b0;
      end
      if (batt_low) st_bld <= 1'b1;
      if (alarm_hit && st2[7:4] != 4'h0) st_pend <= 1'b1;
    end

  assign int_mode  = st2[7:4];
  assign test_mode = st2[0];
  assign hour24    = st_24h;
  assign irq       = st_pend && (st2[7:4] != 4'h0);

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe); // R10
  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd1 && !batt_low) |=> (!st_poc && !st_bld)); // R6
  AST_NONE_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr2 && wr_data[7:4] == 4'h0) |=> !irq); // R9
  AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr1 && wr_data[7] && !batt_low) |=> (!st_poc && !st_bld && st2 == 8'h00 && clk_rst)); // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_time, wr_alarm})); // R4
endmodule

// File: tb/rtc_i2c_front_test.sv
module rtc_i2c_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;
  localparam logic [3:0] AH = 4'b0110;
  localparam int POR = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic sda_line;
  logic [55:0] time_v = '0;
  logic [23:0] alarm_v = '0;
  logic wr_time, wr_alarm, irq, test_mode, hour24, clk_rst;
  logic [2:0] wr_idx;
  logic [7:0] wr_data;
  logic [3:0] int_mode;
  logic batt_low = 1'b0;
  logic alarm_hit = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] exp_st2 = 8'h00;
  logic [7:0] rbuf [0:15];
  logic [7:0] wbuf [0:15];
  logic [1:0] lg_k [0:255];
  logic [2:0] lg_i [0:255];
  logic [7:0] lg_d [0:255];
  logic [7:0] wr_cnt = '0;
  int rst_pulses = 0;

  assign sda_line = ~(m_low | sda_oe);

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_i2c_front #(.ADDR_HI(AH), .POR_CYCLES(POR)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .time_in(time_v), .alarm_in(alarm_v), .wr_time(wr_time), .wr_alarm(wr_alarm),
    .wr_idx(wr_idx), .wr_data(wr_data), .batt_low(batt_low), .alarm_hit(alarm_hit),
    .irq(irq), .int_mode(int_mode), .test_mode(test_mode), .hour24(hour24), .clk_rst(clk_rst));

  always @(posedge clk) begin
    if (wr_time || wr_alarm) begin
      lg_k[wr_cnt] <= wr_time ? 2'd1 : 2'd2;
      lg_i[wr_cnt] <= wr_idx;
      lg_d[wr_cnt] <= wr_data;
      wr_cnt <= wr_cnt + 8'd1;
    end
    if (clk_rst) rst_pulses <= rst_pulses + 1;
  end

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] c, input int i);
    if (c == 3'd1 && i == 0) return exp_st2;
    if (c == 3'd2 && i < 7) return time_v[8*i +: 8];
    if (c == 3'd3 && i < 3) return time_v[8*(i+4) +: 8];
    if (c == 3'd5 && i < 3) return alarm_v[8*i +: 8];
    return 8'hFF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; qwait(); scl = 1'b1; qwait(); m_low = 1'b1; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; qwait(); scl = 1'b1; qwait(); m_low = 1'b0; qwait();
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; qwait(); scl = 1'b1; qwait(); qwait(); scl = 1'b0; qwait();
    end
    m_low = 1'b0; qwait(); scl = 1'b1; qwait(); ack = ~sda_line; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic rd_byte(input bit ack_it, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qwait(); scl = 1'b1; qwait(); b[i] = sda_line; qwait(); scl = 1'b0;
    end
    m_low = ack_it; qwait(); scl = 1'b1; qwait(); qwait(); scl = 1'b0; qwait(); m_low = 1'b0;
  endtask

  task automatic rd_txn(input logic [2:0] c, input int n, output bit ack);
    bus_start();
    wr_byte({AH, c, 1'b1}, ack);
    if (ack) for (int i = 0; i < n; i++) rd_byte(i != n-1, rbuf[i]);
    bus_stop();
  endtask

  task automatic wr_txn(input logic [2:0] c, input int n, output bit ack);
    bit a2;
    bus_start();
    wr_byte({AH, c, 1'b0}, ack);
    if (ack) for (int i = 0; i < n; i++) wr_byte(rev8(wbuf[i]), a2);
    bus_stop();
  endtask

  task automatic rd_st1(input string tag, input logic [7:0] exp);
    bit ack;
    rd_txn(3'd0, 1, ack);
    chk({tag, " ack"}, 32'(ack), 32'd1);
    chk(tag, 32'(rev8(rbuf[0])), 32'(exp));
  endtask

  task automatic wr_one(input logic [2:0] c, input logic [7:0] v);
    bit ack;
    wbuf[0] = v;
    wr_txn(c, 1, ack);
    chk("R1 write ack", 32'(ack), 32'd1);
  endtask

  task automatic pulse_hit();
    alarm_hit = 1'b1; @(negedge clk); alarm_hit = 1'b0; @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    int base, nexp, c, n;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset sda_oe", 32'(sda_oe), 32'd0);
    chk("R5 reset irq", 32'(irq), 32'd0);
    chk("R5 reset hour24", 32'(hour24), 32'd0);
    chk("R8 reset int_mode", 32'(int_mode), 32'd0);

    // R10: quiet window after reset
    bus_start(); wr_byte({AH, 3'd0, 1'b1}, ack); bus_stop();
    chk("R10 no ack while busy", 32'(ack), 32'd0);
    repeat (POR) @(negedge clk);

    // R1: foreign address
    bus_start(); wr_byte({AH ^ 4'b0001, 3'd0, 1'b1}, ack); bus_stop();
    chk("R1 foreign address nack", 32'(ack), 32'd0);

    // R2/R5/R6: power-on flag, wire order, clear on read
    rd_txn(3'd0, 1, ack);
    chk("R1 ack", 32'(ack), 32'd1);
    chk("R2 wire byte reversed", 32'(rbuf[0]), 32'h80);
    chk("R5 power-on flag", 32'(rev8(rbuf[0])), 32'h01);
    rd_st1("R6 cleared after read", 8'h00);

    // R6: set wins over read-clear
    batt_low = 1'b1;
    rd_st1("R5 low battery flag", 8'h02);
    rd_st1("R6 held condition re-sets", 8'h02);
    batt_low = 1'b0;
    rd_st1("R6 set before drop", 8'h02);
    rd_st1("R6 clear after drop", 8'h00);

    // R8: status 2
    wr_one(3'd1, 8'h41); exp_st2 = 8'h41;
    chk("R8 int_mode", 32'(int_mode), 32'h4);
    chk("R8 test_mode", 32'(test_mode), 32'd1);
    rd_txn(3'd1, 1, ack);
    chk("R8 readback", 32'(rev8(rbuf[0])), 32'h41);

    // R9: interrupt
    pulse_hit();
    chk("R9 irq set", 32'(irq), 32'd1);
    rd_st1("R5 pending bit", 8'h04);
    chk("R6 read drops irq", 32'(irq), 32'd0);
    pulse_hit();
    chk("R9 irq set again", 32'(irq), 32'd1);
    wr_one(3'd1, 8'h00); exp_st2 = 8'h00;
    chk("R9 none drops irq", 32'(irq), 32'd0);
    pulse_hit();
    chk("R9 event ignored in none", 32'(irq), 32'd0);
    rd_st1("R9 no pending in none", 8'h00);

    // R7: reset command
    wr_one(3'd1, 8'h20);
    batt_low = 1'b1; @(negedge clk); batt_low = 1'b0;
    base = rst_pulses;
    wr_one(3'd0, 8'hC0); exp_st2 = 8'h00;
    chk("R7 reset pulse", 32'(rst_pulses - base), 32'd1);
    chk("R7 hour24 kept", 32'(hour24), 32'd1);
    chk("R7 status2 cleared", 32'(int_mode), 32'd0);
    rd_st1("R7 flags after reset", 8'h40);
    wr_one(3'd0, 8'h00);
    chk("R7 plain write no pulse", 32'(rst_pulses - base), 32'd1);
    chk("R7 hour24 written 0", 32'(hour24), 32'd0);
    wr_one(3'd0, 8'h40);
    rd_st1("R7 hour24 readback", 8'h40);

    // R11: NACK ends read, repeated start
    time_v = 56'h0123_4567_89AB_CD; exp_st2 = 8'h11;
    wr_one(3'd1, 8'h11);
    bus_start(); wr_byte({AH, 3'd2, 1'b1}, ack);
    rd_byte(1'b1, rbuf[0]); rd_byte(1'b0, rbuf[1]);
    chk("R11 released after nack", 32'(sda_oe), 32'd0);
    bus_start(); wr_byte({AH, 3'd1, 1'b1}, ack);
    chk("R11 repeated start ack", 32'(ack), 32'd1);
    rd_byte(1'b0, rbuf[2]); bus_stop();
    chk("R3 time byte0", 32'(rev8(rbuf[0])), 32'(time_v[7:0]));
    chk("R3 time byte1", 32'(rev8(rbuf[1])), 32'(time_v[15:8]));
    chk("R11 status2 after restart", 32'(rev8(rbuf[2])), 32'h11);

    // R4: ignored command
    base = wr_cnt;
    for (int i = 0; i < 3; i++) wbuf[i] = 8'h5A;
    wr_txn(3'd4, 3, ack);
    chk("R4 command 4 ignored", 32'(wr_cnt - 8'(base)), 32'd0);

    // R3: random reads
    for (int k = 0; k < 28; k++) begin
      c = int'($urandom % 7) + 1;
      n = int'($urandom % 9) + 1;
      time_v = {$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF;
      alarm_v = 24'($urandom);
      rd_txn(3'(c), n, ack);
      chk("R1 random read ack", 32'(ack), 32'd1);
      for (int i = 0; i < n; i++)
        chk($sformatf("R3 cmd %0d byte %0d", c, i), 32'(rev8(rbuf[i])), 32'(exp_rd(3'(c), i)));
    end

    // R4/R2: random writes
    for (int k = 0; k < 18; k++) begin
      c = int'($urandom % 6) + 2;
      n = int'($urandom % 8) + 1;
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      base = wr_cnt;
      wr_txn(3'(c), n, ack);
      chk("R1 random write ack", 32'(ack), 32'd1);
      nexp = 0;
      for (int i = 0; i < n; i++) begin
        logic [1:0] ek; logic [2:0] ei; bit have;
        have = 1'b0; ek = 2'd0; ei = 3'd0;
        if (c == 2 && i < 7) begin have = 1'b1; ek = 2'd1; ei = 3'(i); end
        if (c == 3 && i < 3) begin have = 1'b1; ek = 2'd1; ei = 3'(i + 4); end
        if (c == 5 && i < 3) begin have = 1'b1; ek = 2'd2; ei = 3'(i); end
        if (have) begin
          chk("R4 strobe kind", 32'(lg_k[8'(base + nexp)]), 32'(ek));
          chk("R4 strobe index", 32'(lg_i[8'(base + nexp)]), 32'(ei));
          chk("R2 strobe data", 32'(lg_d[8'(base + nexp)]), 32'(wbuf[i]));
          nexp++;
        end
      end
      chk("R4 strobe count", 32'(wr_cnt - 8'(base)), 32'(nexp));
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule